// File: doc/BRIEF.md
# Modular Delta Codec

This block turns a stream of N-bit samples into a stream of N-bit differences, and turns such a difference stream back into samples. It has two independent halves that share a clock and a reset. The encoder sends the first sample it accepts unchanged and marks it as a seed. Every later output is the current sample minus the sample before it. The result is truncated to N bits, so it wraps modulo 2^N and is never widened. The decoder loads its running value from a seed word. For every other word it adds the incoming difference to the value it rebuilt last, also modulo 2^N. Because both halves wrap the same way, chaining the encoder into the decoder gives back the original samples exactly.

The subtractor is one shared adder. It takes the minuend, the bitwise inverse of the subtrahend and a carry-in of one. That adder also produces a signed-overflow flag, equal to the carry into the top bit XOR the carry out of it. The flag goes out beside each result as a status bit and never changes the wrapped value. Every port uses a valid/ready handshake. Each output is registered, which gives one cycle of latency, and holds while downstream is not ready. A restart pulse re-arms seed handling in both halves without resetting them.

Top module: `wrap_delta_codec`

## Requirements
- R1: While reset is high and on the first cycle after it, both `*_out_valid` outputs are 0. With no output pending, both `*_in_ready` outputs are 1.
- R2: After reset, the first word the encoder accepts comes out unchanged with `enc_out_seed`=1 and `enc_out_ovf`=0.
- R3: Every later encoder output equals the current sample minus the previous accepted sample, modulo 2^N, with `enc_out_seed`=0.
- R4: `enc_out_ovf` is 1 exactly when the signed difference of the two samples falls outside the range [-2^(N-1), 2^(N-1)-1]. `enc_out_data` still carries the wrapped value.
- R5: The decoder treats a word as a seed in any of three cases: `dec_in_seed`=1, it is the first accepted word after reset, or it is the first accepted word after a restart. A seed word is output unchanged with `dec_out_seed`=1 and `dec_out_ovf`=0.
- R6: Any other decoder word produces the previous decoder output plus the word, modulo 2^N, with `dec_out_seed`=0. `dec_out_ovf` flags signed overflow of that sum.
- R7: A word accepted on clock edge k appears on the output with valid high after edge k, so the latency is one cycle.
- R8: While an output is valid and its ready input is low, the output data and flags hold steady and the matching `*_in_ready` is 0.
- R9: A `restart` pulse makes the next word accepted by each half a seed. A word accepted in the same cycle as the pulse counts as that seed.
- R10: Feeding encoder output into the decoder rebuilds every input sample. With N=3, the inputs 100, 011, 100 encode to 100 (seed), 111 and 001, and decode back to 100, 011, 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Re-arms seed handling in both halves |
| enc_in_valid | input | 1 | Encoder input sample valid |
| enc_in_ready | output | 1 | Encoder can accept a sample |
| enc_in_data | input | N | Encoder input sample |
| enc_out_valid | output | 1 | Encoder output valid |
| enc_out_ready | input | 1 | Downstream accepts encoder output |
| enc_out_data | output | N | Seed or wrapped difference |
| enc_out_seed | output | 1 | Marks the seed word |
| enc_out_ovf | output | 1 | Signed overflow of the subtraction |
| dec_in_valid | input | 1 | Decoder input word valid |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_data | input | N | Seed or difference |
| dec_in_seed | input | 1 | Forces the word to be taken as a seed |
| dec_out_valid | output | 1 | Decoder output valid |
| dec_out_ready | input | 1 | Downstream accepts decoder output |
| dec_out_data | output | N | Rebuilt sample |
| dec_out_seed | output | 1 | Marks a seed-loaded sample |
| dec_out_ovf | output | 1 | Signed overflow of the addition |

## Verification
The bench builds the codec with N=3 and the explicit ripple-carry adder variant. At that width all 64 ordered pairs of samples can be driven through each half one by one, so every wrap case and every case of the overflow flag is reached. This includes the alternation between the most negative value 100 and the most positive value 011. The small word size also lets the listed three-sample vector be checked bit for bit. Random round-trip streams, run with random downstream backpressure, then exercise the stall path together with the chained lossless rebuild.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic {
      WD_ADD_BEHAV  = 1'b0,
      WD_ADD_RIPPLE = 1'b1
   } wd_adder_e;
endpackage

// File: rtl/wd_adder.sv
module wd_adder #(
   parameter int               N     = 16,
   parameter wd_pkg::wd_adder_e STYLE = wd_pkg::WD_ADD_BEHAV
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam int LOW = N - 1;

   if (N < 2) begin : g_bad_width
      $error("wd_adder: N must be at least 2");
   end

   if (STYLE == wd_pkg::WD_ADD_RIPPLE) begin : g_ripple
      logic [N:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      assign cout = carry[N];
      assign ovf  = carry[N] ^ carry[N-1];
   end else begin : g_behav
      logic [LOW:0] low_sum;
      logic [1:0]   top_sum;
      assign low_sum = {1'b0, a[LOW-1:0]} + {1'b0, b[LOW-1:0]} + {{LOW{1'b0}}, cin};
      assign top_sum = {1'b0, a[N-1]} + {1'b0, b[N-1]} + {1'b0, low_sum[LOW]};
      assign sum  = {top_sum[0], low_sum[LOW-1:0]};
      assign cout = top_sum[1];
      assign ovf  = top_sum[1] ^ low_sum[LOW];
   end
endmodule

// File: rtl/wd_out_reg.sv
module wd_out_reg #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         out_ready,
   output logic         out_valid,
   output logic [W-1:0] q,
   output logic         in_ready
);
   if (W < 1) begin : g_bad_width
      $error("wd_out_reg: W must be positive");
   end

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         q         <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         q         <= d;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/wd_encoder.sv
module wd_encoder #(
   parameter int                N     = 16,
   parameter wd_pkg::wd_adder_e STYLE = wd_pkg::WD_ADD_BEHAV
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [N-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [N-1:0] out_data,
   output logic         out_seed,
   output logic         out_ovf
);
   localparam int PW = N + 2;

   logic [N-1:0]  prev_q;
   logic          armed_q;
   logic          take;
   logic          seed_now;
   logic [N-1:0]  diff;
   logic          diff_cout;
   logic          diff_ovf;
   logic [PW-1:0] payload;
   logic [PW-1:0] held;

   assign take     = in_valid && in_ready;
   assign seed_now = armed_q || restart;

   wd_adder #(.N(N), .STYLE(STYLE)) sub_i (
      .a   (in_data),
      .b   (~prev_q),
      .cin (1'b1),
      .sum (diff),
      .cout(diff_cout),
      .ovf (diff_ovf)
   );

   assign payload = seed_now ? {1'b1, 1'b0, in_data}
                             : {1'b0, diff_ovf, diff};

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q  <= '0;
         armed_q <= 1'b1;
      end else if (take) begin
         prev_q  <= in_data;
         armed_q <= 1'b0;
      end else if (restart) begin
         armed_q <= 1'b1;
      end
   end

   wd_out_reg #(.W(PW)) oreg_i (
      .clk      (clk),
      .rst      (rst),
      .load     (take),
      .d        (payload),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .q        (held),
      .in_ready (in_ready)
   );

   assign out_seed = held[PW-1];
   assign out_ovf  = held[PW-2];
   assign out_data = held[N-1:0];

   logic unused_carry;
   assign unused_carry = diff_cout;
endmodule

// File: rtl/wd_decoder.sv
module wd_decoder #(
   parameter int                N     = 16,
   parameter wd_pkg::wd_adder_e STYLE = wd_pkg::WD_ADD_BEHAV
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [N-1:0] in_data,
   input  logic         in_seed,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [N-1:0] out_data,
   output logic         out_seed,
   output logic         out_ovf
);
   localparam int PW = N + 2;

   logic [N-1:0]  prev_q;
   logic          armed_q;
   logic          take;
   logic          seed_now;
   logic [N-1:0]  rebuilt;
   logic [N-1:0]  sum;
   logic          sum_cout;
   logic          sum_ovf;
   logic [PW-1:0] payload;
   logic [PW-1:0] held;

   assign take     = in_valid && in_ready;
   assign seed_now = armed_q || restart || in_seed;

   wd_adder #(.N(N), .STYLE(STYLE)) add_i (
      .a   (prev_q),
      .b   (in_data),
      .cin (1'b0),
      .sum (sum),
      .cout(sum_cout),
      .ovf (sum_ovf)
   );

   assign rebuilt = seed_now ? in_data : sum;
   assign payload = {seed_now, !seed_now && sum_ovf, rebuilt};

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q  <= '0;
         armed_q <= 1'b1;
      end else if (take) begin
         prev_q  <= rebuilt;
         armed_q <= 1'b0;
      end else if (restart) begin
         armed_q <= 1'b1;
      end
   end

   wd_out_reg #(.W(PW)) oreg_i (
      .clk      (clk),
      .rst      (rst),
      .load     (take),
      .d        (payload),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .q        (held),
      .in_ready (in_ready)
   );

   assign out_seed = held[PW-1];
   assign out_ovf  = held[PW-2];
   assign out_data = held[N-1:0];

   logic unused_carry;
   assign unused_carry = sum_cout;
endmodule

// File: rtl/wrap_delta_codec.sv
module wrap_delta_codec #(
   parameter int                N     = 16,
   parameter wd_pkg::wd_adder_e STYLE = wd_pkg::WD_ADD_BEHAV
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   input  logic         enc_in_valid,
   output logic         enc_in_ready,
   input  logic [N-1:0] enc_in_data,
   output logic         enc_out_valid,
   input  logic         enc_out_ready,
   output logic [N-1:0] enc_out_data,
   output logic         enc_out_seed,
   output logic         enc_out_ovf,
   input  logic         dec_in_valid,
   output logic         dec_in_ready,
   input  logic [N-1:0] dec_in_data,
   input  logic         dec_in_seed,
   output logic         dec_out_valid,
   input  logic         dec_out_ready,
   output logic [N-1:0] dec_out_data,
   output logic         dec_out_seed,
   output logic         dec_out_ovf
);
   if (N < 2) begin : g_bad_width
      $error("wrap_delta_codec: N must be at least 2");
   end

   wd_encoder #(.N(N), .STYLE(STYLE)) enc_i (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .in_valid (enc_in_valid),
      .in_ready (enc_in_ready),
      .in_data  (enc_in_data),
      .out_valid(enc_out_valid),
      .out_ready(enc_out_ready),
      .out_data (enc_out_data),
      .out_seed (enc_out_seed),
      .out_ovf  (enc_out_ovf)
   );

   wd_decoder #(.N(N), .STYLE(STYLE)) dec_i (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .in_valid (dec_in_valid),
      .in_ready (dec_in_ready),
      .in_data  (dec_in_data),
      .in_seed  (dec_in_seed),
      .out_valid(dec_out_valid),
      .out_ready(dec_out_ready),
      .out_data (dec_out_data),
      .out_seed (dec_out_seed),
      .out_ovf  (dec_out_ovf)
   );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         restart,
   input logic         enc_in_valid,
   input logic         enc_in_ready,
   input logic         enc_out_valid,
   input logic         enc_out_ready,
   input logic [N-1:0] enc_out_data,
   input logic         enc_out_seed,
   input logic         enc_out_ovf,
   input logic         dec_in_valid,
   input logic         dec_in_ready,
   input logic         dec_out_valid,
   input logic         dec_out_ready,
   input logic [N-1:0] dec_out_data,
   input logic         dec_out_seed,
   input logic         dec_out_ovf
);
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!enc_out_valid && !dec_out_valid));

   a_r7_enc_latency: assert property (@(posedge clk) disable iff (rst)
      (enc_in_valid && enc_in_ready) |=> enc_out_valid);

   a_r7_dec_latency: assert property (@(posedge clk) disable iff (rst)
      (dec_in_valid && dec_in_ready) |=> dec_out_valid);

   a_r8_enc_hold: assert property (@(posedge clk) disable iff (rst)
      (enc_out_valid && !enc_out_ready) |=>
         (enc_out_valid && $stable(enc_out_data) && $stable(enc_out_seed) && $stable(enc_out_ovf)));

   a_r8_dec_hold: assert property (@(posedge clk) disable iff (rst)
      (dec_out_valid && !dec_out_ready) |=>
         (dec_out_valid && $stable(dec_out_data) && $stable(dec_out_seed) && $stable(dec_out_ovf)));

   a_r8_enc_stall: assert property (@(posedge clk) disable iff (rst)
      (enc_out_valid && !enc_out_ready) |-> !enc_in_ready);

   a_r8_dec_stall: assert property (@(posedge clk) disable iff (rst)
      (dec_out_valid && !dec_out_ready) |-> !dec_in_ready);

   a_r2_enc_seed_clean: assert property (@(posedge clk) disable iff (rst)
      (enc_out_valid && enc_out_seed) |-> !enc_out_ovf);

   a_r5_dec_seed_clean: assert property (@(posedge clk) disable iff (rst)
      (dec_out_valid && dec_out_seed) |-> !dec_out_ovf);

   a_r9_enc_restart_seed: assert property (@(posedge clk) disable iff (rst)
      (restart && enc_in_valid && enc_in_ready) |=> enc_out_seed);

   a_r9_dec_restart_seed: assert property (@(posedge clk) disable iff (rst)
      (restart && dec_in_valid && dec_in_ready) |=> dec_out_seed);
endmodule

bind wrap_delta_codec wd_checker #(.N(N)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .restart      (restart),
   .enc_in_valid (enc_in_valid),
   .enc_in_ready (enc_in_ready),
   .enc_out_valid(enc_out_valid),
   .enc_out_ready(enc_out_ready),
   .enc_out_data (enc_out_data),
   .enc_out_seed (enc_out_seed),
   .enc_out_ovf  (enc_out_ovf),
   .dec_in_valid (dec_in_valid),
   .dec_in_ready (dec_in_ready),
   .dec_out_valid(dec_out_valid),
   .dec_out_ready(dec_out_ready),
   .dec_out_data (dec_out_data),
   .dec_out_seed (dec_out_seed),
   .dec_out_ovf  (dec_out_ovf)
);

// File: tb/wrap_delta_codec_tb_top.sv
module wrap_delta_codec_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 3;
   localparam int MAXP       = (1 << (W - 1)) - 1;
   localparam int MINN       = -(1 << (W - 1));
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic restart = 1'b0;
   logic chain = 1'b0;

   logic         e_iv = 1'b0;
   logic [W-1:0] e_id = '0;
   logic         e_ordy = 1'b1;
   logic         d_iv = 1'b0;
   logic [W-1:0] d_id = '0;
   logic         d_is = 1'b0;
   logic         d_ordy = 1'b1;

   logic         enc_in_ready, enc_out_valid, enc_out_seed, enc_out_ovf, enc_out_ready;
   logic [W-1:0] enc_out_data;
   logic         dec_in_valid, dec_in_ready, dec_in_seed;
   logic [W-1:0] dec_in_data;
   logic         dec_out_valid, dec_out_seed, dec_out_ovf;
   logic [W-1:0] dec_out_data;

   assign dec_in_valid  = chain ? enc_out_valid : d_iv;
   assign dec_in_data   = chain ? enc_out_data  : d_id;
   assign dec_in_seed   = chain ? enc_out_seed  : d_is;
   assign enc_out_ready = chain ? dec_in_ready  : e_ordy;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [W-1:0] seq [0:63];

   wrap_delta_codec #(.N(W), .STYLE(wd_pkg::WD_ADD_RIPPLE)) dut_i (
      .clk          (clk),
      .rst          (rst),
      .restart      (restart),
      .enc_in_valid (e_iv),
      .enc_in_ready (enc_in_ready),
      .enc_in_data  (e_id),
      .enc_out_valid(enc_out_valid),
      .enc_out_ready(enc_out_ready),
      .enc_out_data (enc_out_data),
      .enc_out_seed (enc_out_seed),
      .enc_out_ovf  (enc_out_ovf),
      .dec_in_valid (dec_in_valid),
      .dec_in_ready (dec_in_ready),
      .dec_in_data  (dec_in_data),
      .dec_in_seed  (dec_in_seed),
      .dec_out_valid(dec_out_valid),
      .dec_out_ready(d_ordy),
      .dec_out_data (dec_out_data),
      .dec_out_seed (dec_out_seed),
      .dec_out_ovf  (dec_out_ovf)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int sx(input logic [W-1:0] v);
      return v[W-1] ? int'(v) - (1 << W) : int'(v);
   endfunction

   function automatic logic [W-1:0] wsub(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] r;
      r = a - b;
      return r;
   endfunction

   function automatic logic [W-1:0] wadd(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] r;
      r = a + b;
      return r;
   endfunction

   function automatic logic sub_ovf(input logic [W-1:0] a, input logic [W-1:0] b);
      int r;
      r = sx(a) - sx(b);
      return (r > MAXP) || (r < MINN);
   endfunction

   function automatic logic add_ovf(input logic [W-1:0] a, input logic [W-1:0] b);
      int r;
      r = sx(a) + sx(b);
      return (r > MAXP) || (r < MINN);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; restart = 1'b0; chain = 1'b0;
      e_iv = 1'b0; e_ordy = 1'b1; d_iv = 1'b0; d_is = 1'b0; d_ordy = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic enc_send(input string req, input logic [W-1:0] x, input logic rs,
                           input logic [W-1:0] ed, input logic es, input logic eo);
      @(negedge clk);
      e_iv = 1'b1; e_id = x; e_ordy = 1'b1; restart = rs;
      @(negedge clk);
      e_iv = 1'b0; restart = 1'b0;
      chk(req, "enc valid", int'(enc_out_valid), 1);
      chk(req, "enc data", int'(enc_out_data), int'(ed));
      chk(req, "enc seed", int'(enc_out_seed), int'(es));
      chk(req, "enc ovf", int'(enc_out_ovf), int'(eo));
   endtask

   task automatic dec_send(input string req, input logic [W-1:0] d, input logic is, input logic rs,
                           input logic [W-1:0] ed, input logic es, input logic eo);
      @(negedge clk);
      d_iv = 1'b1; d_id = d; d_is = is; d_ordy = 1'b1; restart = rs;
      @(negedge clk);
      d_iv = 1'b0; d_is = 1'b0; restart = 1'b0;
      chk(req, "dec valid", int'(dec_out_valid), 1);
      chk(req, "dec data", int'(dec_out_data), int'(ed));
      chk(req, "dec seed", int'(dec_out_seed), int'(es));
      chk(req, "dec ovf", int'(dec_out_ovf), int'(eo));
   endtask

   // R1: idle outputs right after reset
   task automatic t_reset();
      do_reset();
      chk("R1", "enc_out_valid", int'(enc_out_valid), 0);
      chk("R1", "dec_out_valid", int'(dec_out_valid), 0);
      chk("R1", "enc_in_ready", int'(enc_in_ready), 1);
      chk("R1", "dec_in_ready", int'(dec_in_ready), 1);
   endtask

   // R10: the three-sample vector through both halves separately
   task automatic t_vector();
      do_reset();
      enc_send("R10", 3'b100, 1'b0, 3'b100, 1'b1, 1'b0);
      enc_send("R10", 3'b011, 1'b0, 3'b111, 1'b0, 1'b1);
      enc_send("R10", 3'b100, 1'b0, 3'b001, 1'b0, 1'b1);
      dec_send("R10", 3'b100, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0);
      dec_send("R10", 3'b111, 1'b0, 1'b0, 3'b011, 1'b0, 1'b1);
      dec_send("R10", 3'b001, 1'b0, 1'b0, 3'b100, 1'b0, 1'b1);
   endtask

   // R2 R3 R4: every ordered pair through the encoder
   task automatic t_enc_pairs();
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            do_reset();
            enc_send("R2", W'(a), 1'b0, W'(a), 1'b1, 1'b0);
            enc_send("R3_R4", W'(b), 1'b0, wsub(W'(b), W'(a)), 1'b0, sub_ovf(W'(b), W'(a)));
         end
      end
   endtask

   // R5 R6: every seed/difference pair through the decoder
   task automatic t_dec_pairs();
      for (int a = 0; a < (1 << W); a++) begin
         for (int d = 0; d < (1 << W); d++) begin
            do_reset();
            dec_send("R5", W'(a), 1'b1, 1'b0, W'(a), 1'b1, 1'b0);
            dec_send("R6", W'(d), 1'b0, 1'b0, wadd(W'(a), W'(d)), 1'b0, add_ovf(W'(a), W'(d)));
         end
      end
   endtask

   // R5: first word after reset is a seed even without the flag; flag mid-stream reloads
   task automatic t_dec_seed_rules();
      do_reset();
      dec_send("R5", 3'b110, 1'b0, 1'b0, 3'b110, 1'b1, 1'b0);
      dec_send("R6", 3'b011, 1'b0, 1'b0, wadd(3'b110, 3'b011), 1'b0, add_ovf(3'b110, 3'b011));
      dec_send("R5", 3'b010, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0);
      dec_send("R6", 3'b010, 1'b0, 1'b0, 3'b100, 1'b0, 1'b1);
   endtask

   // R9: restart pulse alone and restart coincident with a transfer
   task automatic t_restart();
      do_reset();
      enc_send("R9", 3'd1, 1'b0, 3'd1, 1'b1, 1'b0);
      enc_send("R9", 3'd4, 1'b0, wsub(3'd4, 3'd1), 1'b0, sub_ovf(3'd4, 3'd1));
      dec_send("R9", 3'd5, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0);
      dec_send("R9", 3'd1, 1'b0, 1'b0, 3'd6, 1'b0, add_ovf(3'd5, 3'd1));
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      repeat (2) @(negedge clk);
      enc_send("R9", 3'd6, 1'b0, 3'd6, 1'b1, 1'b0);
      enc_send("R9", 3'd7, 1'b0, 3'd1, 1'b0, 1'b0);
      dec_send("R9", 3'd3, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0);
      dec_send("R9", 3'd2, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1);
      enc_send("R9", 3'd2, 1'b1, 3'd2, 1'b1, 1'b0);
      dec_send("R9", 3'd7, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
   endtask

   // R7 R8: latency and hold under backpressure
   task automatic t_backpressure();
      do_reset();
      @(negedge clk);
      e_ordy = 1'b0; e_iv = 1'b1; e_id = 3'd5;
      @(negedge clk);
      e_id = 3'd2;
      chk("R7", "enc valid after one edge", int'(enc_out_valid), 1);
      chk("R7", "enc data after one edge", int'(enc_out_data), 5);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8", "held data", int'(enc_out_data), 5);
         chk("R8", "held seed", int'(enc_out_seed), 1);
         chk("R8", "stalled in_ready", int'(enc_in_ready), 0);
      end
      e_ordy = 1'b1;
      @(negedge clk);
      e_iv = 1'b0;
      chk("R8", "next word after release", int'(enc_out_data), int'(wsub(3'd2, 3'd5)));
      chk("R8", "seed after release", int'(enc_out_seed), 0);
      @(negedge clk);
      chk("R7", "drained", int'(enc_out_valid), 0);
   endtask

   // R10: chained round trip with random downstream readiness
   task automatic t_roundtrip(input string name, input int len);
      int ei = 0;
      int eo = 0;
      int dq = 0;
      int guard = 0;
      do_reset();
      chain = 1'b1;
      while (dq < len && guard < 4000) begin
         @(negedge clk);
         guard++;
         d_ordy = ($urandom_range(3) != 0);
         e_iv   = (ei < len) && ($urandom_range(4) != 0);
         e_id   = (ei < len) ? seq[ei] : '0;
         #1;
         if (e_iv && enc_in_ready) ei++;
         if (enc_out_valid && enc_out_ready) begin
            chk("R10", {name, " enc data"}, int'(enc_out_data),
                (eo == 0) ? int'(seq[0]) : int'(wsub(seq[eo], seq[eo-1])));
            chk("R10", {name, " enc seed"}, int'(enc_out_seed), (eo == 0) ? 1 : 0);
            eo++;
         end
         if (dec_out_valid && d_ordy) begin
            chk("R10", {name, " dec data"}, int'(dec_out_data), int'(seq[dq]));
            dq++;
         end
      end
      chk("R10", {name, " words rebuilt"}, dq, len);
      @(negedge clk);
      e_iv = 1'b0; chain = 1'b0; d_ordy = 1'b1;
   endtask

   initial begin
      t_reset();
      t_vector();
      t_enc_pairs();
      t_dec_pairs();
      t_dec_seed_rules();
      t_restart();
      t_backpressure();
      for (int i = 0; i < 64; i++) seq[i] = (i % 2 == 0) ? 3'b100 : 3'b011;
      t_roundtrip("alternating extremes", 64);
      for (int i = 0; i < 64; i++) seq[i] = W'($urandom);
      t_roundtrip("random", 64);
      for (int i = 0; i < 64; i++) seq[i] = (i % 3 == 0) ? 3'b111 : ((i % 3 == 1) ? 3'b000 : 3'b100);
      t_roundtrip("mixed edges", 64);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule